// File: doc/BRIEF.md
# Shielded-Column Black-Level Estimator

This block sits on a digitised sensor line stream, one pixel per valid cycle. It keeps a column index that restarts at the line-start strobe. From that index it picks out the interior samples of the light-shielded column bands, sums them, and turns the sum into a rounded per-line black level. It then subtracts the current black level from the image pixels. The result is clamped at zero and delivered one cycle after the raw pixel.

Each line is laid out as follows: a few empty cells, then a leading shielded band, then the image, then a trailing shielded band. In single-tap mode both bands contribute. The trailing band arrives after the image, so a line's image is corrected with the black level of the previous non-skipped line. In dual-tap mode a tap carries only the leading band and a shorter image. That line's own level is ready before its first image pixel, so the line is corrected with it. The empty cells and the outermost column on each side of a band collect leaked light, so none of them is ever summed. Whole lines from shielded rows are flagged at their start and leave the level untouched.

Top module: `shield_black_level`

## Requirements
- R1: The pixel that has both `pix_valid` and `line_start` set is column 0. Pixels seen after reset and before any such pixel are outside every region: they pass through raw, with `out_image` low, and they never update the black level.
- R2: The following columns never contribute to the sum: columns 0 to 3 (empty), column 4 and column 23 (edges of the leading band), and, in single-tap mode, the first and last trailing-band columns. With the default image width these are columns 4057 and 4075; with a 40-column image they are columns 64 and 82.
- R3: In single-tap mode the level is (S + 17) / 35, using integer division. S is the sum of leading columns 5 to 22 and the 17 interior trailing columns, so the result is the mean rounded half up.
- R4: In dual-tap mode the level is (S + 9) / 18, using integer division. S is the sum of columns 5 to 22.
- R5: `dark_valid` pulses for exactly one cycle per non-skipped line. It coincides with the update of `dark_level`, two clock edges after the last contributing pixel is sampled.
- R6: When `skip_line` is high with the line-start pixel, that line produces no `dark_valid` pulse and `dark_level` keeps its value.
- R7: `dual_tap` and `skip_line` are sampled only with the line-start pixel. Changing either of them later in the line has no effect on that line.
- R8: One cycle after each input cycle, `out_valid` equals the previous `pix_valid`. For image columns with `corr_en` high, `out_data` is max(0, raw − `dark_level`). In every other case `out_data` is the raw pixel.
- R9: Single-tap image pixels are corrected with the level that stood before the line began. Dual-tap image pixels are corrected with the level of their own line.
- R10: Reset clears `dark_level`, `dark_valid`, `out_valid`, `out_image` and `out_data` to zero.
- R11: Full-scale shielded samples (4095 at 12 bits) give a level of 4095 in both modes, with no wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_valid | input | 1 | Pixel present this cycle |
| pix_data | input | PIX_W | Raw pixel value |
| line_start | input | 1 | Marks column 0; only honoured with `pix_valid` |
| skip_line | input | 1 | Line is from shielded rows; sampled at line start |
| dual_tap | input | 1 | 1 = dual-tap line layout; sampled at line start |
| corr_en | input | 1 | Enables subtraction on image columns |
| dark_level | output | PIX_W | Current black-level estimate |
| dark_valid | output | 1 | One-cycle pulse when `dark_level` is refreshed |
| out_valid | output | 1 | Output pixel present |
| out_image | output | 1 | Output pixel lies in the image region |
| out_data | output | PIX_W | Corrected or passed-through pixel |

## Verification
The checks assume that `pix_data` is held at zero while `pix_valid` is low during reset. They also assume that consecutive contributing pixels are never closer than one band apart, so two refreshes cannot fall on adjacent cycles. The stimulus starts every line with a single line-start pixel. It inserts idle cycles only between pixels, and never before column 0 of a line has been sent. Lines follow one another with several idle cycles between them, so each refresh has settled before the next line's image pixels arrive.

// File: rtl/bl_pkg.sv
`timescale 1ns/1ps
package bl_pkg;

   // Clamp-at-zero subtraction shared by the correction stage.
   function automatic logic [15:0] sat_sub16(input logic [15:0] a, input logic [15:0] b);
      return (a > b) ? (a - b) : 16'd0;
   endfunction

   // Number of bits needed to hold the sum of n samples of w bits.
   function automatic int sum_width(input int w, input int n);
      return w + $clog2(n + 1);
   endfunction

endpackage

// File: rtl/bl_col_tracker.sv
`timescale 1ns/1ps
module bl_col_tracker #(
   parameter int EMPTY_COLS       = 4,
   parameter int LEAD_DARK        = 20,
   parameter int TRAIL_DARK       = 19,
   parameter int ACTIVE_COLS      = 4033,
   parameter int DUAL_ACTIVE_COLS = 2016
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pix_valid,
   input  logic line_start,
   input  logic dual_tap,
   input  logic skip_line,
   output logic qual,
   output logic last_qual,
   output logic is_image,
   output logic line_dual,
   output logic line_skip,
   output logic line_head
);
   localparam int IMG_LO_I   = EMPTY_COLS + LEAD_DARK;
   localparam int IDLE_I     = IMG_LO_I + ACTIVE_COLS + TRAIL_DARK;
   localparam int IDX_W      = $clog2(IDLE_I + 1);

   localparam logic [IDX_W-1:0] C_LEAD_LO  = IDX_W'(EMPTY_COLS + 1);
   localparam logic [IDX_W-1:0] C_LEAD_HI  = IDX_W'(IMG_LO_I - 2);
   localparam logic [IDX_W-1:0] C_IMG_LO   = IDX_W'(IMG_LO_I);
   localparam logic [IDX_W-1:0] C_IMG_HI_S = IDX_W'(IMG_LO_I + ACTIVE_COLS - 1);
   localparam logic [IDX_W-1:0] C_IMG_HI_D = IDX_W'(IMG_LO_I + DUAL_ACTIVE_COLS - 1);
   localparam logic [IDX_W-1:0] C_TR_LO    = IDX_W'(IMG_LO_I + ACTIVE_COLS + 1);
   localparam logic [IDX_W-1:0] C_TR_HI    = IDX_W'(IDLE_I - 2);
   localparam logic [IDX_W-1:0] C_IDLE     = IDX_W'(IDLE_I);

   logic [IDX_W-1:0] col_q, idx;
   logic             mode_q, skip_q;
   logic             in_lead, in_trail, img_hi_ok;

   assign line_head = pix_valid && line_start;
   assign idx       = line_head ? '0 : col_q;
   assign line_dual = line_head ? dual_tap  : mode_q;
   assign line_skip = line_head ? skip_line : skip_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         col_q  <= C_IDLE;
         mode_q <= 1'b0;
         skip_q <= 1'b0;
      end else if (pix_valid) begin
         col_q <= (idx == C_IDLE) ? C_IDLE : idx + 1'b1;
         if (line_start) begin
            mode_q <= dual_tap;
            skip_q <= skip_line;
         end
      end
   end

   assign in_lead   = (idx >= C_LEAD_LO) && (idx <= C_LEAD_HI);
   assign in_trail  = !line_dual && (idx >= C_TR_LO) && (idx <= C_TR_HI);
   assign img_hi_ok = line_dual ? (idx <= C_IMG_HI_D) : (idx <= C_IMG_HI_S);

   assign qual      = pix_valid && (in_lead || in_trail);
   assign last_qual = qual && (line_dual ? (idx == C_LEAD_HI) : (idx == C_TR_HI));
   assign is_image  = pix_valid && (idx >= C_IMG_LO) && img_hi_ok;

endmodule

// File: rtl/bl_accum.sv
`timescale 1ns/1ps
module bl_accum #(
   parameter int PIX_W = 12,
   parameter int SUM_W = 18
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pix_valid,
   input  logic             line_head,
   input  logic             qual,
   input  logic             last_qual,
   input  logic             line_dual,
   input  logic             line_skip,
   input  logic [PIX_W-1:0] pix_data,
   output logic             fin_go,
   output logic             fin_dual,
   output logic [SUM_W-1:0] fin_sum
);
   logic [SUM_W-1:0] acc_q, base, addend, nxt;

   assign base   = line_head ? '0 : acc_q;
   assign addend = qual ? {{(SUM_W-PIX_W){1'b0}}, pix_data} : '0;
   assign nxt    = base + addend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q    <= '0;
         fin_go   <= 1'b0;
         fin_dual <= 1'b0;
         fin_sum  <= '0;
      end else begin
         fin_go <= last_qual && !line_skip;
         if (pix_valid) acc_q <= nxt;
         if (last_qual) begin
            fin_sum  <= nxt;
            fin_dual <= line_dual;
         end
      end
   end

endmodule

// File: rtl/bl_recip_div.sv
`timescale 1ns/1ps
module bl_recip_div #(
   parameter int SUM_W   = 18,
   parameter int OUT_W   = 12,
   parameter int DIVISOR = 35,
   parameter bit ROUND   = 1'b1
) (
   input  logic [SUM_W-1:0] sum,
   output logic [OUT_W-1:0] quot
);
   localparam int NUM_W = SUM_W + 2;
   localparam int D2    = 2 * DIVISOR;
   localparam int DC    = $clog2(D2);
   localparam int K     = NUM_W + DC + 1;
   localparam longint unsigned SCALE = 64'd1 << K;
   localparam longint unsigned RECIP = (SCALE + longint'(D2) - 1) / longint'(D2);
   localparam int M_W   = K - DC + 2;
   localparam int P_W   = NUM_W + M_W;
   localparam logic [M_W-1:0] RECIP_V = M_W'(RECIP);

   if (K > 60) begin : g_k_err
      $error("bl_recip_div: reciprocal scale too wide");
   end
   if (P_W - K <= OUT_W) begin : g_w_err
      $error("bl_recip_div: product too narrow for quotient");
   end

   logic [NUM_W-1:0] bias, num;
   logic [P_W-1:0]   prod, shifted;

   if (ROUND) begin : g_round
      assign bias = NUM_W'(DIVISOR);
   end else begin : g_trunc
      assign bias = '0;
   end

   // floor((2*sum + bias) / (2*DIVISOR)) through a fixed reciprocal
   assign num     = {1'b0, sum, 1'b0} + bias;
   assign prod    = {{M_W{1'b0}}, num} * {{NUM_W{1'b0}}, RECIP_V};
   assign shifted = prod >> K;
   assign quot    = (|shifted[P_W-1:OUT_W]) ? '1 : shifted[OUT_W-1:0];

endmodule

// File: rtl/bl_correct.sv
`timescale 1ns/1ps
module bl_correct #(
   parameter int PIX_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pix_valid,
   input  logic             is_image,
   input  logic             corr_en,
   input  logic [PIX_W-1:0] pix_data,
   input  logic [PIX_W-1:0] dark_level,
   output logic             out_valid,
   output logic             out_image,
   output logic [PIX_W-1:0] out_data
);
   logic [PIX_W:0] diff;
   logic [PIX_W-1:0] clamped;

   assign diff    = {1'b0, pix_data} - {1'b0, dark_level};
   assign clamped = diff[PIX_W] ? '0 : diff[PIX_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_image <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= pix_valid;
         out_image <= is_image;
         out_data  <= (is_image && corr_en) ? clamped : pix_data;
      end
   end

endmodule

// File: rtl/shield_black_level.sv
`timescale 1ns/1ps
module shield_black_level #(
   parameter int PIX_W            = 12,
   parameter int EMPTY_COLS       = 4,
   parameter int LEAD_DARK        = 20,
   parameter int TRAIL_DARK       = 19,
   parameter int ACTIVE_COLS      = 4033,
   parameter int DUAL_ACTIVE_COLS = 2016,
   parameter bit ROUND            = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pix_valid,
   input  logic [PIX_W-1:0] pix_data,
   input  logic             line_start,
   input  logic             skip_line,
   input  logic             dual_tap,
   input  logic             corr_en,
   output logic [PIX_W-1:0] dark_level,
   output logic             dark_valid,
   output logic             out_valid,
   output logic             out_image,
   output logic [PIX_W-1:0] out_data
);
   import bl_pkg::*;

   localparam int N_LEAD   = LEAD_DARK - 2;
   localparam int N_SINGLE = N_LEAD + TRAIL_DARK - 2;
   localparam int SUM_W    = sum_width(PIX_W, N_SINGLE);

   if (EMPTY_COLS < 1 || LEAD_DARK < 3 || TRAIL_DARK < 3) begin : g_band_err
      $error("shield_black_level: band sizes too small");
   end
   if (DUAL_ACTIVE_COLS > ACTIVE_COLS || DUAL_ACTIVE_COLS < 1) begin : g_dual_err
      $error("shield_black_level: dual image width out of range");
   end

   logic qual, last_qual, is_image, line_dual, line_skip, line_head;
   logic fin_go, fin_dual;
   logic [SUM_W-1:0] fin_sum;
   logic [PIX_W-1:0] q_single, q_dual;

   bl_col_tracker #(
      .EMPTY_COLS(EMPTY_COLS), .LEAD_DARK(LEAD_DARK), .TRAIL_DARK(TRAIL_DARK),
      .ACTIVE_COLS(ACTIVE_COLS), .DUAL_ACTIVE_COLS(DUAL_ACTIVE_COLS)
   ) u_track (
      .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .line_start(line_start),
      .dual_tap(dual_tap), .skip_line(skip_line), .qual(qual), .last_qual(last_qual),
      .is_image(is_image), .line_dual(line_dual), .line_skip(line_skip),
      .line_head(line_head)
   );

   bl_accum #(.PIX_W(PIX_W), .SUM_W(SUM_W)) u_acc (
      .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .line_head(line_head),
      .qual(qual), .last_qual(last_qual), .line_dual(line_dual), .line_skip(line_skip),
      .pix_data(pix_data), .fin_go(fin_go), .fin_dual(fin_dual), .fin_sum(fin_sum)
   );

   bl_recip_div #(.SUM_W(SUM_W), .OUT_W(PIX_W), .DIVISOR(N_SINGLE), .ROUND(ROUND)) u_div_s (
      .sum(fin_sum), .quot(q_single)
   );

   bl_recip_div #(.SUM_W(SUM_W), .OUT_W(PIX_W), .DIVISOR(N_LEAD), .ROUND(ROUND)) u_div_d (
      .sum(fin_sum), .quot(q_dual)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dark_level <= '0;
         dark_valid <= 1'b0;
      end else begin
         dark_valid <= fin_go;
         if (fin_go) dark_level <= fin_dual ? q_dual : q_single;
      end
   end

   bl_correct #(.PIX_W(PIX_W)) u_corr (
      .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .is_image(is_image),
      .corr_en(corr_en), .pix_data(pix_data), .dark_level(dark_level),
      .out_valid(out_valid), .out_image(out_image), .out_data(out_data)
   );

endmodule

// File: rtl/shield_black_level_chk.sv
`timescale 1ns/1ps
module shield_black_level_chk #(
   parameter int PIX_W = 12
) (
   input logic             clk,
   input logic             rst_n,
   input logic             pix_valid,
   input logic [PIX_W-1:0] pix_data,
   input logic [PIX_W-1:0] dark_level,
   input logic             dark_valid,
   input logic             out_valid,
   input logic             out_image,
   input logic [PIX_W-1:0] out_data
);
   AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      dark_valid |=> !dark_valid);                                           // R5
   AST_LEVEL_ONLY_ON_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(dark_level) |-> dark_valid);                                   // R6
   AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      pix_valid |=> out_valid);                                               // R8
   AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      !pix_valid |=> !out_valid);                                             // R8
   AST_IMAGE_HAS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      out_image |-> out_valid);                                               // R1
   AST_CORR_NOT_ABOVE_RAW: assert property (@(posedge clk) disable iff (!rst_n)
      out_image |-> (out_data <= $past(pix_data)));                           // R8
   AST_NONIMAGE_RAW: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_image) |-> (out_data == $past(pix_data)));           // R2
endmodule

bind shield_black_level shield_black_level_chk #(.PIX_W(PIX_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_data(pix_data),
   .dark_level(dark_level), .dark_valid(dark_valid), .out_valid(out_valid),
   .out_image(out_image), .out_data(out_data)
);

// File: tb/shield_black_level_test.sv
`timescale 1ns/1ps
module shield_black_level_test;

   localparam int IMG_LO   = 24;
   localparam int LEN_S    = 83;   // 4 + 20 + 40 + 19
   localparam int LEN_D    = 40;   // 4 + 20 + 16

   typedef struct packed {
      logic        dual;
      logic        skip;
      logic        corr;
      logic        flip;
      logic        gap;
      logic [11:0] d;
      logic [11:0] bump;
      logic [7:0]  bcol;
      logic [11:0] expr;
      logic [11:0] img;
   } vec_t;

   localparam int NV = 11;
   localparam vec_t TBL [NV] = '{
      '{1'b0,1'b0,1'b1,1'b0,1'b0,12'd100, 12'd17, 8'd81,12'd100, 12'd500},
      '{1'b0,1'b0,1'b1,1'b0,1'b1,12'd100, 12'd18, 8'd5, 12'd101, 12'd500},
      '{1'b0,1'b1,1'b1,1'b0,1'b0,12'd900, 12'd0,  8'd5, 12'd101, 12'd500},
      '{1'b0,1'b0,1'b1,1'b0,1'b0,12'd200, 12'd105,8'd22,12'd203, 12'd50},
      '{1'b1,1'b0,1'b1,1'b0,1'b1,12'd50,  12'd9,  8'd22,12'd51,  12'd300},
      '{1'b1,1'b0,1'b0,1'b0,1'b0,12'd60,  12'd8,  8'd5, 12'd60,  12'd300},
      '{1'b0,1'b0,1'b1,1'b1,1'b0,12'd70,  12'd35, 8'd81,12'd71,  12'd300},
      '{1'b1,1'b0,1'b1,1'b0,1'b0,12'd4095,12'd0,  8'd5, 12'd4095,12'd4000},
      '{1'b0,1'b0,1'b1,1'b0,1'b0,12'd4095,12'd0,  8'd5, 12'd4095,12'd4000},
      '{1'b0,1'b0,1'b1,1'b0,1'b0,12'd10,  12'd0,  8'd5, 12'd10,  12'd1000},
      '{1'b0,1'b0,1'b1,1'b0,1'b1,12'd10,  12'd0,  8'd5, 12'd10,  12'd1000}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pix_valid = 1'b0;
   logic [11:0] pix_data = '0;
   logic        line_start = 1'b0;
   logic        skip_line = 1'b0;
   logic        dual_tap = 1'b0;
   logic        corr_en = 1'b0;
   logic [11:0] dark_level;
   logic        dark_valid;
   logic        out_valid;
   logic        out_image;
   logic [11:0] out_data;

   int    checks = 0;
   int    errors = 0;
   int    dv_cnt = 0;
   int    cur_ref = 0;
   bit    done = 1'b0;
   logic  nx_dual = 1'b0, nx_skip = 1'b0, nx_corr = 1'b0;
   logic  pend_v = 1'b0, pend_img = 1'b0;
   int    pend_out = 0;
   string pend_tag = "R8";

   shield_black_level #(.PIX_W(12), .ACTIVE_COLS(40), .DUAL_ACTIVE_COLS(16)) uut (
      .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_data(pix_data),
      .line_start(line_start), .skip_line(skip_line), .dual_tap(dual_tap),
      .corr_en(corr_en), .dark_level(dark_level), .dark_valid(dark_valid),
      .out_valid(out_valid), .out_image(out_image), .out_data(out_data)
   );

   always #2 clk = ~clk;

   always @(negedge clk) if (rst_n && dark_valid) dv_cnt++;

   task automatic check_eq(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic check_pending();
      check_eq(pend_tag, "out_valid", int'(out_valid), int'(pend_v));
      if (pend_v) begin
         check_eq(pend_tag, "out_image", int'(out_image), int'(pend_img));
         check_eq(pend_tag, "out_data", int'(out_data), pend_out);
      end
   endtask

   task automatic step(input logic v, input logic ls, input int d, input logic img,
                       input int eo, input string tag);
      @(negedge clk);
      check_pending();
      pix_valid  = v;
      line_start = ls;
      pix_data   = 12'(d);
      dual_tap   = nx_dual;
      skip_line  = nx_skip;
      corr_en    = nx_corr;
      pend_v     = v;
      pend_img   = img;
      pend_out   = eo;
      pend_tag   = tag;
   endtask

   function automatic int pix_val(input vec_t v, input int idx);
      int im;
      im = int'(v.img) + (idx % 8);
      if (im > 4095) im = 4095;
      if (idx < 4) return 3000;                      // empty cells, R2
      if (idx == 4 || idx == 23) return 4000;        // leading edges, R2
      if (idx <= 22) return (idx == int'(v.bcol)) ? int'(v.d) + int'(v.bump) : int'(v.d);
      if (v.dual || idx < 64) return im;
      if (idx == 64 || idx == 82) return 4000;       // trailing edges, R2
      return (idx == int'(v.bcol)) ? int'(v.d) + int'(v.bump) : int'(v.d);
   endfunction

   task automatic run_line(input vec_t v);
      int    len, dv0, d, eo;
      logic  img;
      string rtag;
      len = v.dual ? LEN_D : LEN_S;
      dv0 = dv_cnt;
      nx_dual = v.dual;
      nx_skip = v.skip;
      nx_corr = v.corr;
      for (int idx = 0; idx < len; idx++) begin
         if (v.gap && (idx % 5) == 4) step(1'b0, 1'b0, 0, 1'b0, 0, "R8");
         if (v.flip && idx == 3) begin
            nx_dual = 1'b1;        // R7: mid-line change
            nx_skip = 1'b1;
         end
         d   = pix_val(v, idx);
         img = (idx >= IMG_LO) && (idx < (v.dual ? LEN_D : IMG_LO + 40));
         if (v.dual && !v.skip && idx == IMG_LO) cur_ref = int'(v.expr);   // R9
         eo = (img && v.corr) ? ((d > cur_ref) ? d - cur_ref : 0) : d;
         step(1'b1, idx == 0, d, img, eo, v.dual ? "R9" : "R8");
      end
      nx_skip = 1'b0;
      for (int k = 0; k < 3; k++) step(1'b0, 1'b0, 0, 1'b0, 0, "R8");
      if (v.skip)             rtag = "R6";
      else if (v.flip)        rtag = "R7";
      else if (v.d == 12'd4095) rtag = "R11";
      else if (v.dual)        rtag = "R4 R2";
      else                    rtag = "R3 R2";
      check_eq(rtag, "dark_level", int'(dark_level), int'(v.expr));
      check_eq("R5", "dark_valid pulses", dv_cnt - dv0, v.skip ? 0 : 1);
      if (!v.skip) cur_ref = int'(v.expr);
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not finish");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10: reset state
      check_eq("R10", "dark_level", int'(dark_level), 0);
      check_eq("R10", "dark_valid", int'(dark_valid), 0);
      check_eq("R10", "out_valid", int'(out_valid), 0);
      rst_n = 1'b1;
      nx_corr = 1'b1;
      // R1: pixels before any line start stay outside every region
      for (int k = 0; k < 30; k++) step(1'b1, 1'b0, 700 + k, 1'b0, 700 + k, "R1");
      for (int k = 0; k < 3; k++) step(1'b0, 1'b0, 0, 1'b0, 0, "R1");
      check_eq("R1", "dark_valid pulses", dv_cnt, 0);
      check_eq("R1", "dark_level", int'(dark_level), 0);

      for (int i = 0; i < NV; i++) run_line(TBL[i]);

      // R10: reset in the middle of operation clears the level
      @(negedge clk);
      check_pending();
      pix_valid = 1'b0;
      pend_v = 1'b0;
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      check_eq("R10", "dark_level after reset", int'(dark_level), 0);
      check_eq("R10", "out_data after reset", int'(out_data), 0);
      rst_n = 1'b1;
      cur_ref = 0;
      run_line(TBL[9]);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule